// File: doc/BRIEF.md
# PHY Interrupt Aggregator

This block collects one-cycle event pulses from the link, auto-negotiation and fault logic of an Ethernet PHY. It holds each one in a sticky status bit until software reads it. One 16-bit interrupt register carries the eight status flags in its low byte and a matching mask of enables in its high byte. A single interrupt pin is driven while any enabled flag is pending. A polarity bit in a separate configuration register selects whether that pin is active high or active low.

The register side is a plain address/strobe port, so it can sit behind a serial management slave. A read strobe aimed at the interrupt register returns the flags and clears them at the same clock edge. Any event that arrives in that same cycle survives the clear. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every status bit and the polarity bit read back as 0, and `irq_o` is 0.
- R2: A pulse on `evt_i[i]` sets status bit i of the interrupt register (address 17) at the next clock edge. The source assignment is: bit 0 link status change, bit 1 remote fault, bit 2 auto-negotiation complete, bit 3 page received, bit 4 parallel detect fault, bits 5 to 7 spare.
- R3: A status bit stays set until a clock edge with `reg_rd_i` high and `reg_addr_i` = 17. That read returns {enables[7:0], status[7:0]} on `reg_rdata_o` in the same cycle, and the status byte is 0 after the edge.
- R4: An event that arrives in the same cycle as a clearing read leaves its status bit set after the edge.
- R5: A write to address 17 loads `reg_wdata_i[15:8]` into the enables. Bits 7:0 of that write leave the status byte unchanged.
- R6: At each clock edge `irq_o` takes the value (OR over i of status[i] AND enable[i]) XOR polarity, computed from the values held before that edge. The pin therefore follows the registers with one cycle of delay.
- R7: Address 16 holds the polarity at bit 14 (0 = active high, 1 = active low). A write to 16 changes only that bit, and a read returns it at bit 14 with every other bit 0.
- R8: A read of any other address returns 0. A write to any other address changes no readable state and does not change `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event pulses, one per status bit |
| reg_addr_i | input | 5 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rd_i | input | 1 | Read strobe (clears status when aimed at the interrupt register) |
| reg_rdata_o | output | 16 | Read data, combinational from address and state |
| irq_o | output | 1 | Interrupt pin, polarity programmable |

## Verification
A lost or phantom status bit shows up on the next read of address 17. When that bit is enabled, it also shows up on `irq_o` one edge after it goes wrong. A wrong enable or polarity bit shows at once on the matching readback, and on the pin at the next edge. A clear that lands on the wrong cycle, or that wipes an event arriving at the same moment, becomes visible on the read after it. For that reason the bench places events and clearing reads in the same cycle, both on purpose and at random.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int unsigned IRQ_SRC_N = 8;

  // Status bit index for each event source
  typedef enum logic [2:0] {
    SRC_LINK_CHG  = 3'd0,
    SRC_REM_FAULT = 3'd1,
    SRC_AN_DONE   = 3'd2,
    SRC_PAGE_RX   = 3'd3,
    SRC_PD_FAULT  = 3'd4,
    SRC_SPARE5    = 3'd5,
    SRC_SPARE6    = 3'd6,
    SRC_SPARE7    = 3'd7
  } irq_src_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_nxt;
  logic [N-1:0] stat_ce;

  for (genvar g = 0; g < N; g++) begin : g_cell
    always_comb begin
      stat_ce[g]  = clr | evt[g];
      stat_nxt[g] = (stat_q[g] & ~clr) | evt[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[g] <= 1'b0;
      else if (stat_ce[g]) stat_q[g] <= stat_nxt[g];
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned N        = 8,
  parameter int unsigned CFG_ADDR = 16,
  parameter int unsigned IRQ_ADDR = 17,
  parameter int unsigned POL_BIT  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic [N-1:0]      stat,
  output logic [N-1:0]      en,
  output logic              pol,
  output logic              clr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned EN_LSB = DATA_W - N;
  localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(IRQ_ADDR);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  logic          sel_irq, sel_cfg;
  logic          en_ce, pol_ce;
  logic [N-1:0]  en_q, en_nxt;
  logic          pol_q, pol_nxt;
  logic          unused_wdata;

  always_comb begin
    sel_irq = (addr == IRQ_A);
    sel_cfg = (addr == CFG_A);
    en_ce   = wr & sel_irq;
    en_nxt  = wdata[EN_LSB +: N];
    pol_ce  = wr & sel_cfg;
    pol_nxt = wdata[POL_BIT];
    clr     = rd & sel_irq;
  end

  assign unused_wdata = ^wdata[EN_LSB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= 1'b0;
    else if (pol_ce) pol_q <= pol_nxt;
  end

  always_comb begin
    rdata = '0;
    if (sel_irq) begin
      rdata[EN_LSB +: N] = en_q;
      rdata[N-1:0]       = stat;
    end else if (sel_cfg) begin
      rdata[POL_BIT] = pol_q;
    end
  end

  assign en  = en_q;
  assign pol = pol_q;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] en,
  input  logic         pol,
  output logic         pin
);
  logic pin_q, pin_nxt;

  always_comb pin_nxt = (|(stat & en)) ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_nxt;
  end

  assign pin = pin_q;
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl #(
  parameter int unsigned NUM_SRC  = phy_irq_pkg::IRQ_SRC_N,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 2 * NUM_SRC,
  parameter int unsigned CFG_ADDR = 16,
  parameter int unsigned IRQ_ADDR = 17,
  parameter int unsigned POL_BIT  = 14
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic               reg_rd_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic               rst_n_sync;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] en;
  logic               pol;
  logic               stat_clr;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  irq_status_bank #(.N(NUM_SRC)) u_stat (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .evt   (evt_i),
    .clr   (stat_clr),
    .stat  (stat)
  );

  irq_ctrl_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N        (NUM_SRC),
    .CFG_ADDR (CFG_ADDR),
    .IRQ_ADDR (IRQ_ADDR),
    .POL_BIT  (POL_BIT)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .addr  (reg_addr_i),
    .wr    (reg_wr_i),
    .wdata (reg_wdata_i),
    .rd    (reg_rd_i),
    .stat  (stat),
    .en    (en),
    .pol   (pol),
    .clr   (stat_clr),
    .rdata (reg_rdata_o)
  );

  irq_pin_drv #(.N(NUM_SRC)) u_pin (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .stat  (stat),
    .en    (en),
    .pol   (pol),
    .pin   (irq_o)
  );
endmodule

// File: rtl/phy_irq_ctrl_sva.sv
module phy_irq_ctrl_sva #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt,
  input logic         clr,
  input logic         irq_wr,
  input logic [N-1:0] stat,
  input logic [N-1:0] en,
  input logic         pol,
  input logic         irq
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat & $past(stat)) == $past(stat)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (stat == '0));

  assert_clear_keeps_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat == $past(evt)));

  assert_wr_keeps_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wr && !clr && evt == '0) |=> $stable(stat));

  assert_pin_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ((|($past(stat) & $past(en))) ^ $past(pol))));
endmodule

bind phy_irq_ctrl phy_irq_ctrl_sva #(.N(NUM_SRC)) u_sva (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .evt    (evt_i),
  .clr    (stat_clr),
  .irq_wr (reg_wr_i && (reg_addr_i == ADDR_W'(IRQ_ADDR))),
  .stat   (stat),
  .en     (en),
  .pol    (pol),
  .irq    (irq_o)
);

// File: tb/sim_phy_irq_ctrl.sv
module sim_phy_irq_ctrl;
  import phy_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  evt_i;
  logic [4:0]  reg_addr_i;
  logic        reg_wr_i;
  logic [15:0] reg_wdata_i;
  logic        reg_rd_i;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  logic [7:0] m_stat = '0, m_en = '0;
  logic       m_pol = 1'b0, m_pin = 1'b0;

  always #5 clk = ~clk;

  phy_irq_ctrl u0 (
    .clk(clk), .rst_ni(rst_ni), .evt_i(evt_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rd_i(reg_rd_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] f_read(input logic [4:0] a);
    if (a == 5'd17) return {m_en, m_stat};
    if (a == 5'd16) return {1'b0, m_pol, 14'b0};
    return 16'h0000;
  endfunction

  function automatic string f_tag(input logic [4:0] a);
    if (a == 5'd17) return "R3";
    if (a == 5'd16) return "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic step(input logic [7:0] ev, input logic [4:0] a, input logic wr,
                      input logic [15:0] wd, input logic rd, input string tag);
    logic [7:0] n_stat, n_en;
    logic       n_pol, n_pin;
    check({tag, "/R6 pin"}, {15'b0, irq_o}, {15'b0, m_pin});
    evt_i = ev; reg_addr_i = a; reg_wr_i = wr; reg_wdata_i = wd; reg_rd_i = rd;
    #1;
    if (rd) check({tag, "/", f_tag(a), " read"}, reg_rdata_o, f_read(a));
    n_stat = ((rd && a == 5'd17) ? 8'h00 : m_stat) | ev;
    n_en   = (wr && a == 5'd17) ? wd[15:8] : m_en;
    n_pol  = (wr && a == 5'd16) ? wd[14] : m_pol;
    n_pin  = (|(m_stat & m_en)) ^ m_pol;
    @(posedge clk);
    m_stat = n_stat; m_en = n_en; m_pol = n_pol; m_pin = n_pin;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (whole run) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h2C41);
    rst_ni = 1'b0; evt_i = '0; reg_addr_i = '0; reg_wr_i = 0; reg_wdata_i = '0; reg_rd_i = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    step(8'h00, 5'd17, 0, 16'h0, 1, "R1");
    step(8'h00, 5'd16, 0, 16'h0, 1, "R1");
    check("R1 pin", {15'b0, irq_o}, 16'h0000);

    // R2: page received sets bit 3, masked so pin stays low
    step(8'h01 << SRC_PAGE_RX, 5'd0, 0, 16'h0, 0, "R2");
    step(8'h00, 5'd0, 0, 16'h0, 0, "R2");
    check("R2 status", reg_rdata_o, 16'h0000);
    step(8'h00, 5'd17, 0, 16'h0, 1, "R2");   // read clears; shows 0008

    // R5: enable page bit, low byte of write ignored
    step(8'h01 << SRC_PAGE_RX, 5'd0, 0, 16'h0, 0, "R5");
    step(8'h00, 5'd17, 1, 16'h08FF, 0, "R5");
    step(8'h00, 5'd0, 0, 16'h0, 0, "R5");
    step(8'h00, 5'd0, 0, 16'h0, 0, "R6");     // pin now high
    check("R6 pin asserted", {15'b0, irq_o}, 16'h0001);

    // R4: link change arrives with the clearing read
    step(8'h01 << SRC_LINK_CHG, 5'd17, 0, 16'h0, 1, "R4");
    step(8'h00, 5'd17, 0, 16'h0, 1, "R4");
    step(8'h00, 5'd17, 0, 16'h0, 1, "R3");

    // R7: polarity active low
    step(8'h01 << SRC_PD_FAULT, 5'd16, 1, 16'h4000, 0, "R7");
    step(8'h00, 5'd16, 0, 16'h0, 1, "R7");
    step(8'h00, 5'd0, 0, 16'h0, 0, "R7");
    check("R7 pin idle high", {15'b0, irq_o}, 16'h0001);
    step(8'h00, 5'd17, 1, 16'h1000, 0, "R7");
    step(8'h00, 5'd0, 0, 16'h0, 0, "R7");
    step(8'h00, 5'd0, 0, 16'h0, 0, "R7");
    check("R7 pin active low", {15'b0, irq_o}, 16'h0000);
    step(8'h00, 5'd16, 1, 16'hBFFF, 0, "R7");
    step(8'h00, 5'd16, 0, 16'h0, 1, "R7");

    // R8: other address
    step(8'h00, 5'd3, 1, 16'hFFFF, 1, "R8");
    step(8'h00, 5'd3, 0, 16'h0, 1, "R8");
    step(8'h00, 5'd17, 0, 16'h0, 1, "R8");

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  ev;
      logic [4:0]  a;
      logic        wr, rd;
      logic [15:0] wd;
      ev = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      case ($urandom % 3)
        0: a = 5'd16;
        1: a = 5'd17;
        default: a = 5'($urandom);
      endcase
      wr = ($urandom % 6 == 0);
      rd = ($urandom % 4 == 0);
      wd = 16'($urandom);
      step(ev, a, wr, wd, rd, "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule